// File: doc/BRIEF.md
# Delay-Register Indirect Access Bridge

This block sits between a simple synchronous host register port and a small bank of per-timing-mode delay settings that feed a storage-card PHY. Software never addresses the delay settings directly. It reaches them through one 32-bit window register, which holds an entry index, a write value, a returned value, two command strobes and a done flag.

To change a setting, software performs three host writes to the window. The first carries the index and value with both strobes low. The second repeats that word with the write strobe high. The third clears the strobe again. The bank is updated only on the low-to-high change of the write strobe. To fetch a setting, software raises the read strobe together with an index. The bridge copies the selected entry into the return field and raises the done flag. The flag drops once software leaves both strobes low.

The bank contents also leave the block as a flat vector that drives the delay lines. Host signals are plain register-port pins with no handshake: a write is accepted in every cycle in which the write enable is high, and read data is combinational from the address.

Top module: `phy_dly_port`

## Requirements
- R1: The window register (host offset PORT_OFS, default 0x10) has these fields: entry index at bits [7:0], write value at [11:8], returned value at [15:12], write strobe at bit 24, read strobe at bit 25 and done flag at bit 26. All other bits read as zero. The index, write value and strobes read back as they were last written.
- R2: After reset the window register reads 0, and the nine entries 0 through 8 hold 4, 4, 0, 0, 0, 0, 9, 2, 3.
- R3: A host write that takes bit 24 from 0 to 1 stores its write value into the entry its index selects, in that same clock edge.
- R4: While bit 24 stays high, later window writes that change the index or the value do not update any entry.
- R5: A rising write strobe with an index above 8 changes no entry.
- R6: A rising edge of either strobe sets the done flag. The flag stays set while either strobe is high.
- R7: A rising read strobe copies the selected entry into the returned-value field. An index above 8 returns 0.
- R8: The done flag is clear after any window write that leaves both strobes low.
- R9: Host writes to any offset other than PORT_OFS change nothing, and host reads there return 0.
- R10: Output dly_o carries entry i at bits [4*i+3:4*i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write enable |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| dly_o | output | 36 | All nine delay entries, 4 bits each |

## Verification
The assertions assume that reset is applied before the first write. They also assume that the strobes change only through host writes to the window, so each strobe bit has a well-defined earlier value. The bench drives every host access on a falling clock edge, with at most one write per cycle. It never leaves the write enable high across two edges by accident. It samples a quarter period after the falling edge. Out-of-range indices and foreign offsets are driven only in single, separate writes, so their effect on the bank and the window can be observed before the next access.

// File: rtl/phy_dly_pkg.sv
package phy_dly_pkg;
  localparam int IDX_W    = 8;
  localparam int VAL_W    = 4;
  localparam int N_ENT    = 9;
  localparam int IDX_LSB  = 0;
  localparam int WVAL_LSB = 8;
  localparam int RVAL_LSB = 12;
  localparam int WSTB_BIT = 24;
  localparam int RSTB_BIT = 25;
  localparam int DONE_BIT = 26;

  function automatic logic [VAL_W-1:0] ent_init(input int idx);
    case (idx)
      0, 1:    ent_init = 4'd4;
      6:       ent_init = 4'd9;
      7:       ent_init = 4'd2;
      8:       ent_init = 4'd3;
      default: ent_init = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/phy_dly_strobe.sv
module phy_dly_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d,
  output logic q,
  output logic nxt,
  output logic rise
);
  assign nxt  = load ? d : q;
  assign rise = load & d & ~q;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt;
  end
endmodule

// File: rtl/phy_dly_bank.sv
module phy_dly_bank
  import phy_dly_pkg::*;
#(
  parameter int AW  = IDX_W,
  parameter int DW  = VAL_W,
  parameter int NE  = N_ENT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_val,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_val,
  output logic [NE*DW-1:0] flat
);
  logic [DW-1:0] ent_q [NE];

  for (genvar i = 0; i < NE; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                ent_q[i] <= DW'(ent_init(i));
      else if (wr_en && wr_idx == AW'(i))        ent_q[i] <= wr_val;
    end
    assign flat[i*DW +: DW] = ent_q[i];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NE; i++)
      if (rd_idx == AW'(i)) rd_val = ent_q[i];
  end

  AST_OOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || int'(wr_idx) >= NE) |=> $stable(flat)); // R5
endmodule

// File: rtl/phy_dly_port.sv
module phy_dly_port
  import phy_dly_pkg::*;
#(
  parameter int          HOST_AW  = 8,
  parameter logic [7:0]  PORT_OFS = 8'h10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_we,
  input  logic [HOST_AW-1:0]     host_addr,
  input  logic [31:0]            host_wdata,
  output logic [31:0]            host_rdata,
  output logic [N_ENT*VAL_W-1:0] dly_o
);
  localparam int NSTB = 2;

  logic             win_hit, win_wr;
  logic [NSTB-1:0]  stb_q, stb_nxt, stb_rise;
  logic [IDX_W-1:0] idx_q;
  logic [VAL_W-1:0] wval_q, rval_q, bank_rd;
  logic             done_q;
  logic             rsvd_unused;

  assign win_hit     = host_addr == HOST_AW'(PORT_OFS);
  assign win_wr      = host_we && win_hit;
  assign rsvd_unused = ^{host_wdata[31:27], host_wdata[23:16]};

  for (genvar k = 0; k < NSTB; k++) begin : g_stb
    phy_dly_strobe u_stb (
      .clk  (clk),
      .rst_n(rst_n),
      .load (win_wr),
      .d    (host_wdata[WSTB_BIT+k]),
      .q    (stb_q[k]),
      .nxt  (stb_nxt[k]),
      .rise (stb_rise[k])
    );
  end

  phy_dly_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (stb_rise[0]),
    .wr_idx(host_wdata[IDX_LSB +: IDX_W]),
    .wr_val(host_wdata[WVAL_LSB +: VAL_W]),
    .rd_idx(host_wdata[IDX_LSB +: IDX_W]),
    .rd_val(bank_rd),
    .flat  (dly_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      wval_q <= '0;
      rval_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (win_wr) begin
        idx_q  <= host_wdata[IDX_LSB +: IDX_W];
        wval_q <= host_wdata[WVAL_LSB +: VAL_W];
      end
      if (stb_rise[1]) rval_q <= bank_rd;
      if (|stb_rise)        done_q <= 1'b1;
      else if (~|stb_nxt)   done_q <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (win_hit) begin
      host_rdata[IDX_LSB +: IDX_W]  = idx_q;
      host_rdata[WVAL_LSB +: VAL_W] = wval_q;
      host_rdata[RVAL_LSB +: VAL_W] = rval_q;
      host_rdata[WSTB_BIT]          = stb_q[0];
      host_rdata[RSTB_BIT]          = stb_q[1];
      host_rdata[DONE_BIT]          = done_q;
    end
  end

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise[0] |=> !stb_rise[0]); // R4
  AST_DONE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_q[1]) |-> done_q); // R6
  AST_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_q[0]) |-> done_q); // R6
  AST_DONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_q == 2'b00) |-> !done_q); // R8
endmodule

// File: tb/phy_dly_port_tb.sv
module phy_dly_port_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] WIN = 8'h10;

  typedef struct {
    bit          is_ent;
    int          idx;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        host_we = 0;
  logic [7:0]  host_addr = WIN;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [35:0] dly_o;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t sb[$];

  logic [3:0] m_ent [9];
  logic [7:0] m_idx;
  logic [3:0] m_wval, m_rval;
  logic       m_ws, m_rs, m_done;

  always #(CLK_P/2) clk = ~clk;

  phy_dly_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dly_o(dly_o)
  );

  function automatic logic [31:0] win_word();
    return {5'b0, m_done, m_rs, m_ws, 8'b0, m_rval, m_wval, m_idx};
  endfunction

  task automatic win_wr(input logic [7:0] idx, input logic [3:0] val,
                        input logic ws, input logic rs);
    host_addr  = WIN;
    host_wdata = {5'b0, 1'b0, rs, ws, 8'b0, 4'b0, val, idx};
    host_we    = 1;
    if (ws && !m_ws && idx < 9) m_ent[idx] = val;
    if (rs && !m_rs) m_rval = (idx < 9) ? m_ent[idx] : 4'd0;
    if ((ws && !m_ws) || (rs && !m_rs)) m_done = 1;
    else if (!ws && !rs) m_done = 0;
    m_ws = ws; m_rs = rs; m_idx = idx; m_wval = val;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string r);
    host_addr = a;
    sb.push_back('{is_ent: 0, idx: 0, exp: e, req: r});
    @(negedge clk);
  endtask

  task automatic chk_win(input string r);
    chk_rd(WIN, win_word(), r);
  endtask

  task automatic chk_bank(input string r);
    for (int i = 0; i < 9; i++)
      sb.push_back('{is_ent: 1, idx: i, exp: {28'b0, m_ent[i]}, req: r});
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb.pop_front();
        act = it.is_ent ? {28'b0, dly_o[it.idx*4 +: 4]} : host_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s idx=%0d actual=%h expected=%h", it.req, it.idx, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 9; i++) m_ent[i] = (i < 2) ? 4'd4 : (i == 6) ? 4'd9 : (i == 7) ? 4'd2 : (i == 8) ? 4'd3 : 4'd0;
    m_idx = 0; m_wval = 0; m_rval = 0; m_ws = 0; m_rs = 0; m_done = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_win("R2");
    chk_bank("R2_R10");

    // R9: foreign offset
    host_addr = 8'h14; host_wdata = 32'h0100_0305; host_we = 1;
    @(negedge clk); host_we = 0;
    chk_rd(8'h14, 32'h0, "R9");
    chk_win("R9");
    chk_bank("R9");

    // R3: three-step write of entry 3
    win_wr(8'd3, 4'd7, 0, 0);
    chk_win("R1");
    chk_bank("R3_pre");
    win_wr(8'd3, 4'd7, 1, 0);
    chk_win("R6");
    chk_bank("R3");
    // R4: strobe held, new index/value
    win_wr(8'd4, 4'd5, 1, 0);
    chk_bank("R4");
    win_wr(8'd4, 4'd5, 0, 0);
    chk_win("R8");
    chk_bank("R4_after");

    // R5: out-of-range write
    win_wr(8'd9, 4'hF, 0, 0);
    win_wr(8'd9, 4'hF, 1, 0);
    chk_bank("R5");
    win_wr(8'd9, 4'hF, 0, 0);

    // second legal write to last entry
    win_wr(8'd8, 4'hA, 1, 0);
    win_wr(8'd8, 4'hA, 0, 0);
    chk_bank("R3_last");

    // R7: read entry 6
    win_wr(8'd6, 4'd0, 0, 1);
    chk_win("R7");
    win_wr(8'd2, 4'd0, 0, 1);
    chk_win("R6_hold");
    win_wr(8'd2, 4'd0, 0, 0);
    chk_win("R8");
    win_wr(8'd12, 4'd0, 0, 1);
    chk_win("R7_oor");
    win_wr(8'd12, 4'd0, 0, 0);
    win_wr(8'd3, 4'd0, 0, 1);
    chk_win("R7_written");
    win_wr(8'd3, 4'd0, 0, 0);
    chk_win("R1_R8");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule